// File: doc/BRIEF.md
# Receive Cell Buffer with Cell-Available Read Port

This block sits between a physical-layer receiver and an ATM-layer reader. Incoming 16-bit words arrive in fixed groups of `CELL_WORDS` words, one group per cell. They are stored in a buffer that holds `DEPTH_CELLS` whole cells. The reader sees a cell-available flag, which is high only while at least one complete, unread cell is stored. The reader pulls words with an active-low read enable. Word 0 of every cell leaves with a start-of-cell strobe.

A reader that is partway through a cell may keep reading until the cell's last word, even when the available flag has dropped. At a cell boundary, it must wait for the flag before it reads again. The write side has space for a cell reserved when the cell's first word is accepted. So the buffer cannot run out of room in the middle of a cell. A cell whose first word arrives while every slot is taken is dropped whole, and this is recorded as an overrun. The write port cannot stall: `in_accept` tells the source whether the word it offers now will be stored, and every word offered with `in_valid` is used up either way.

A small processor port provides two registers:
- A status register, read only.
- An interrupt register that holds two enables, two clear-on-read event flags and a self-clearing flush command.

The interrupt line is high while any event flag is set and its enable is on.

Top module: `rx_cell_fifo`

## Requirements
- R1: `rx_clav` rises on the clock edge that stores the last word (word `CELL_WORDS-1`) of a cell, and not before. It stays high only while at least one complete cell is stored that the reader has not started.
- R2: Once the reader has taken word 0 of a cell, each further edge with `rx_en_n` low delivers the next word of that cell in order, through the last word. This holds whether or not `rx_clav` is still high.
- R3: When `rx_en_n` is sampled low at a cell boundary while `rx_clav` is high, word 0 of the oldest cell appears on `rx_data` after that edge, with `rx_soc` high for that one word. `rx_soc` is low for every other word.
- R4: Writing a 1 into bit 6 of register 0 empties the buffer at that edge. It also clears both the write and read word positions, so `rx_clav` is low afterwards and the status register reads 8'h01.
- R5: Register 1 (status) reads bit 1 = full, meaning all `DEPTH_CELLS` slots are reserved and a new cell would overrun. It reads bit 0 = empty, meaning no stored word. Bits 7..2 read 0, and writes to register 1 have no effect.
- R6: A cell whose word 0 arrives while full is dropped with all its words. `in_accept` is low for each of those words, and bit 1 (overrun) of register 0 is set.
- R7: `rx_en_n` low at a cell boundary with `rx_clav` low is an underrun. `rx_data` keeps its last value, `rx_soc` stays low, and bit 0 (underrun) of register 0 is set.
- R8: Register 0 reads back the overrun enable in bit 5 and the underrun enable in bit 4. It reads bit 6 as 0. A read of register 0 clears bits 1 and 0, unless an event sets them at the same edge.
- R9: `irq` equals (overrun flag AND bit 5) OR (underrun flag AND bit 4).
- R10: `cpu_rdata` is registered. It shows the addressed register's value from before the edge on which `cpu_rd` is sampled high, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received word is offered this cycle |
| in_data | input | DATA_W | Received word |
| in_accept | output | 1 | The word offered now will be stored |
| rx_en_n | input | 1 | Active-low read enable from the reader |
| rx_clav | output | 1 | A complete unread cell is stored |
| rx_data | output | DATA_W | Word presented to the reader |
| rx_soc | output | 1 | `rx_data` holds word 0 of a cell |
| cpu_addr | input | 1 | Register select (0 interrupt, 1 status) |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Registered read data |
| irq | output | 1 | Enabled event pending |

## Verification
Each result falls due at a known point:
- `rx_data` and `rx_soc` change on the edge that samples `rx_en_n` low.
- `rx_clav` changes on the edge that stores a last word or takes a word 0.
- `cpu_rdata` changes on the edge that samples `cpu_rd`.
- Flush and the event flags take effect on the edge where they occur.
- `in_accept` and `irq` follow the registered state without delay.

The bench drives every input on the falling edge and steps its reference model at the rising edge. It compares all outputs at the next falling edge, so every check looks exactly one edge after its cause. The reference model is kept from requirement-level rules: a queue of words plus counts of reserved and ready cells.

// File: rtl/rxcf_pkg.sv
package rxcf_pkg;
  // register select values
  localparam logic REG_IRQ  = 1'b0;
  localparam logic REG_STAT = 1'b1;

  // interrupt register bit positions
  localparam int BIT_FLUSH  = 6;
  localparam int BIT_OVR_EN = 5;
  localparam int BIT_UND_EN = 4;
  localparam int BIT_OVR    = 1;
  localparam int BIT_UND    = 0;

  // status register bit positions
  localparam int BIT_FULL   = 1;
  localparam int BIT_EMPTY  = 0;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_TAKE  = 2'd1,
    RD_UNDER = 2'd2
  } rd_act_e;
endpackage

// File: rtl/rxcf_wr_ctrl.sv
module rxcf_wr_ctrl #(
  parameter int CELL_WORDS  = 27,
  parameter int DEPTH_CELLS = 4,
  localparam int CAP = CELL_WORDS * DEPTH_CELLS,
  localparam int AW  = $clog2(CAP),
  localparam int IW  = $clog2(CELL_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  input  logic          slots_full,
  output logic          in_accept,
  output logic          wr_fire,
  output logic [AW-1:0] wr_addr,
  output logic          cell_open,
  output logic          cell_done,
  output logic          ovr_evt
);
  logic [IW-1:0] widx;
  logic [AW-1:0] wptr;
  logic          keep;
  logic          at_start;
  logic          at_last;

  assign at_start  = (widx == '0);
  assign at_last   = (widx == IW'(CELL_WORDS - 1));
  // a cell is admitted at word 0 only when a whole slot is free
  assign in_accept = at_start ? !slots_full : keep;
  assign wr_fire   = in_valid && in_accept && !flush;
  assign ovr_evt   = in_valid && !in_accept && !flush;
  assign cell_open = wr_fire && at_start;
  assign cell_done = wr_fire && at_last;
  assign wr_addr   = wptr;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      widx <= '0;
      wptr <= '0;
      keep <= 1'b0;
    end else if (in_valid) begin
      widx <= at_last ? '0 : widx + 1'b1;
      if (at_start) keep <= !slots_full;
      if (wr_fire) wptr <= (wptr == AW'(CAP - 1)) ? '0 : wptr + 1'b1;
    end
  end
endmodule

// File: rtl/rxcf_rd_ctrl.sv
module rxcf_rd_ctrl
  import rxcf_pkg::*;
#(
  parameter int CELL_WORDS  = 27,
  parameter int DEPTH_CELLS = 4,
  localparam int CAP = CELL_WORDS * DEPTH_CELLS,
  localparam int AW  = $clog2(CAP),
  localparam int IW  = $clog2(CELL_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          rx_en_n,
  input  logic          cell_avail,
  output logic          rd_fire,
  output logic [AW-1:0] rd_addr,
  output logic          cell_start,
  output logic          cell_free,
  output logic          und_evt,
  output logic [IW-1:0] rd_pos
);
  logic [IW-1:0] ridx;
  logic [AW-1:0] rptr;
  rd_act_e       act;

  // mid-cell reads always proceed; a boundary read needs a ready cell
  always_comb begin
    act = RD_IDLE;
    if (!rx_en_n && !flush) begin
      if (ridx != '0 || cell_avail) act = RD_TAKE;
      else                          act = RD_UNDER;
    end
  end

  assign rd_fire    = (act == RD_TAKE);
  assign und_evt    = (act == RD_UNDER);
  assign cell_start = rd_fire && (ridx == '0);
  assign cell_free  = rd_fire && (ridx == IW'(CELL_WORDS - 1));
  assign rd_addr    = rptr;
  assign rd_pos     = ridx;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      ridx <= '0;
      rptr <= '0;
    end else if (rd_fire) begin
      ridx <= cell_free ? '0 : ridx + 1'b1;
      rptr <= (rptr == AW'(CAP - 1)) ? '0 : rptr + 1'b1;
    end
  end
endmodule

// File: rtl/rxcf_store.sv
module rxcf_store #(
  parameter int DATA_W      = 16,
  parameter int CELL_WORDS  = 27,
  parameter int DEPTH_CELLS = 4,
  localparam int CAP = CELL_WORDS * DEPTH_CELLS,
  localparam int AW  = $clog2(CAP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  input  logic              first,
  output logic [DATA_W-1:0] rdata,
  output logic              soc
);
  logic [DATA_W-1:0] mem [CAP];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // output word holds when no word is taken
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      soc   <= 1'b0;
    end else begin
      soc <= re && first;
      if (re) rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/rxcf_regs.sv
module rxcf_regs
  import rxcf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_addr,
  input  logic       cpu_wr,
  input  logic       cpu_rd,
  input  logic [7:0] cpu_wdata,
  input  logic       ovr_evt,
  input  logic       und_evt,
  input  logic       full,
  input  logic       empty,
  output logic [7:0] cpu_rdata,
  output logic       flush,
  output logic       irq
);
  logic       ovr_en, und_en;
  logic       ovr_flag, und_flag;
  logic       irq_wr, irq_rd;
  logic [7:0] rd_mux;

  assign irq_wr = cpu_wr && (cpu_addr == REG_IRQ);
  assign irq_rd = cpu_rd && (cpu_addr == REG_IRQ);
  assign flush  = irq_wr && cpu_wdata[BIT_FLUSH];
  assign irq    = (ovr_flag && ovr_en) || (und_flag && und_en);

  always_comb begin
    rd_mux = '0;
    if (cpu_addr == REG_IRQ) begin
      rd_mux[BIT_OVR_EN] = ovr_en;
      rd_mux[BIT_UND_EN] = und_en;
      rd_mux[BIT_OVR]    = ovr_flag;
      rd_mux[BIT_UND]    = und_flag;
    end else begin
      rd_mux[BIT_FULL]   = full;
      rd_mux[BIT_EMPTY]  = empty;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_en    <= 1'b0;
      und_en    <= 1'b0;
      ovr_flag  <= 1'b0;
      und_flag  <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      if (irq_wr) begin
        ovr_en <= cpu_wdata[BIT_OVR_EN];
        und_en <= cpu_wdata[BIT_UND_EN];
      end
      // a new event wins over the clear of a simultaneous read
      if (ovr_evt)     ovr_flag <= 1'b1;
      else if (irq_rd) ovr_flag <= 1'b0;
      if (und_evt)     und_flag <= 1'b1;
      else if (irq_rd) und_flag <= 1'b0;
      if (cpu_rd) cpu_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/rx_cell_fifo.sv
module rx_cell_fifo #(
  parameter int DATA_W      = 16,
  parameter int CELL_WORDS  = 27,
  parameter int DEPTH_CELLS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_accept,
  input  logic              rx_en_n,
  output logic              rx_clav,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_soc,
  input  logic              cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              irq
);
  localparam int CAP = CELL_WORDS * DEPTH_CELLS;
  localparam int AW  = $clog2(CAP);
  localparam int IW  = $clog2(CELL_WORDS);
  localparam int CW  = $clog2(DEPTH_CELLS + 1);
  localparam int UW  = $clog2(CAP + 1);

  logic          flush;
  logic          wr_fire, cell_open, cell_done, ovr_evt;
  logic          rd_fire, cell_start, cell_free, und_evt;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [IW-1:0] rd_pos;
  logic [CW-1:0] slots_used;   // cells reserved by the writer, not yet fully read
  logic [CW-1:0] cells_ready;  // complete cells the reader has not started
  logic [UW-1:0] used_words;
  logic          slots_full, full, empty;

  assign slots_full = (slots_used == CW'(DEPTH_CELLS));
  assign full       = slots_full;
  assign empty      = (used_words == '0);
  assign rx_clav    = (cells_ready != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      slots_used  <= '0;
      cells_ready <= '0;
      used_words  <= '0;
    end else begin
      slots_used  <= slots_used + CW'(cell_open) - CW'(cell_free);
      cells_ready <= cells_ready + CW'(cell_done) - CW'(cell_start);
      used_words  <= used_words + UW'(wr_fire) - UW'(rd_fire);
    end
  end

  rxcf_wr_ctrl #(.CELL_WORDS(CELL_WORDS), .DEPTH_CELLS(DEPTH_CELLS)) u_wr (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .slots_full(slots_full), .in_accept(in_accept), .wr_fire(wr_fire),
    .wr_addr(wr_addr), .cell_open(cell_open), .cell_done(cell_done),
    .ovr_evt(ovr_evt)
  );

  rxcf_rd_ctrl #(.CELL_WORDS(CELL_WORDS), .DEPTH_CELLS(DEPTH_CELLS)) u_rd (
    .clk(clk), .rst_n(rst_n), .flush(flush), .rx_en_n(rx_en_n),
    .cell_avail(rx_clav), .rd_fire(rd_fire), .rd_addr(rd_addr),
    .cell_start(cell_start), .cell_free(cell_free), .und_evt(und_evt),
    .rd_pos(rd_pos)
  );

  rxcf_store #(.DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS), .DEPTH_CELLS(DEPTH_CELLS)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .waddr(wr_addr), .wdata(in_data),
    .re(rd_fire), .raddr(rd_addr), .first(cell_start),
    .rdata(rx_data), .soc(rx_soc)
  );

  rxcf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .ovr_evt(ovr_evt),
    .und_evt(und_evt), .full(full), .empty(empty), .cpu_rdata(cpu_rdata),
    .flush(flush), .irq(irq)
  );
endmodule

// File: rtl/rxcf_checker.sv
module rxcf_checker #(
  parameter int DATA_W      = 16,
  parameter int CELL_WORDS  = 27,
  parameter int DEPTH_CELLS = 4,
  localparam int CAP = CELL_WORDS * DEPTH_CELLS,
  localparam int IW  = $clog2(CELL_WORDS),
  localparam int UW  = $clog2(CAP + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en_n,
  input logic              rx_clav,
  input logic              rx_soc,
  input logic [DATA_W-1:0] rx_data,
  input logic [UW-1:0]     used_words,
  input logic [IW-1:0]     rd_pos,
  input logic              flush
);
  // R1: availability implies a whole cell of words is stored
  assert_clav_has_cell_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clav |-> used_words >= UW'(CELL_WORDS));

  // R2: a read inside a cell always advances and never strobes start
  assert_midcell_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en_n && rd_pos != '0 && !flush) |=> (!rx_soc && rd_pos != $past(rd_pos)));

  // R3: boundary read with a ready cell presents word 0 with the strobe
  assert_first_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en_n && rd_pos == '0 && rx_clav && !flush) |=> rx_soc);

  // R4: flush leaves nothing stored and no cell available
  assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (used_words == '0 && !rx_clav && rd_pos == '0));

  // R6: storage never exceeds its capacity
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    used_words <= UW'(CAP));

  // R7: an underrun holds the output word and gives no strobe
  assert_underrun_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en_n && rd_pos == '0 && !rx_clav && !flush) |=> ($stable(rx_data) && !rx_soc));
endmodule

bind rx_cell_fifo rxcf_checker #(
  .DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS), .DEPTH_CELLS(DEPTH_CELLS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en_n(rx_en_n), .rx_clav(rx_clav),
  .rx_soc(rx_soc), .rx_data(rx_data), .used_words(used_words),
  .rd_pos(rd_pos), .flush(flush)
);

// File: tb/rx_cell_fifo_tb.sv
`timescale 1ns/1ps
module rx_cell_fifo_tb;
  localparam int NW = 27;
  localparam int NC = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        d_valid = 1'b0;
  logic [15:0] d_data = '0;
  logic        d_en_n = 1'b1;
  logic        d_addr = 1'b0;
  logic        d_wr = 1'b0;
  logic        d_rd = 1'b0;
  logic [7:0]  d_wdata = '0;
  string       d_tag = "R10";

  logic        in_accept, rx_clav, rx_soc, irq;
  logic [15:0] rx_data;
  logic [7:0]  cpu_rdata;

  rx_cell_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(d_valid), .in_data(d_data),
    .in_accept(in_accept), .rx_en_n(d_en_n), .rx_clav(rx_clav),
    .rx_data(rx_data), .rx_soc(rx_soc), .cpu_addr(d_addr), .cpu_wr(d_wr),
    .cpu_rd(d_rd), .cpu_wdata(d_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
  );

  int total = 0;
  int bad = 0;

  // reference model state
  logic [15:0] mq[$];
  int   m_widx = 0, m_ridx = 0, m_alloc = 0, m_ready = 0;
  bit   m_keep = 0, m_soc = 0;
  bit   m_ovr = 0, m_und = 0, m_oen = 0, m_uen = 0;
  logic [15:0] m_last = '0;
  logic [7:0]  m_rdata = '0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] irq_reg();
    return {2'b00, m_oen, m_uen, 2'b00, m_ovr, m_und};
  endfunction

  function automatic logic [7:0] stat_reg();
    return {6'b0, m_alloc == NC, mq.size() == 0};
  endfunction

  function automatic bit exp_accept();
    return (m_widx == 0) ? (m_alloc < NC) : m_keep;
  endfunction

  // one clock: inputs already driven, model steps at the rising edge,
  // outputs compared at the following falling edge
  task automatic tick();
    bit flush, ovr_e, und_e, acc, rd_now;
    int da, dr;
    logic [7:0] rv;
    flush = d_wr && d_addr == 1'b0 && d_wdata[6];
    ovr_e = 0; und_e = 0; da = 0; dr = 0; rd_now = d_rd;
    rv = (d_addr == 1'b0) ? irq_reg() : stat_reg();
    @(posedge clk);
    m_soc = 0;
    if (flush) begin
      mq.delete();
      m_widx = 0; m_ridx = 0; m_alloc = 0; m_ready = 0; m_keep = 0;
    end else begin
      if (!d_en_n) begin
        if (m_ridx != 0 || m_ready > 0) begin
          if (m_ridx == 0) begin dr--; m_soc = 1; end
          m_last = mq.pop_front();
          if (m_ridx == NW - 1) begin m_ridx = 0; da--; end
          else m_ridx++;
        end else und_e = 1;
      end
      if (d_valid) begin
        if (m_widx == 0) begin
          acc = (m_alloc < NC); m_keep = acc;
          if (acc) da++;
        end else acc = m_keep;
        if (!acc) ovr_e = 1;
        if (acc) begin
          mq.push_back(d_data);
          if (m_widx == NW - 1) dr++;
        end
        m_widx = (m_widx == NW - 1) ? 0 : m_widx + 1;
      end
      m_alloc += da; m_ready += dr;
    end
    if (d_rd && d_addr == 1'b0) begin m_ovr = 0; m_und = 0; end
    if (ovr_e) m_ovr = 1;
    if (und_e) m_und = 1;
    if (d_wr && d_addr == 1'b0) begin m_oen = d_wdata[5]; m_uen = d_wdata[4]; end
    if (d_rd) m_rdata = rv;
    @(negedge clk);
    chk(rx_clav == (m_ready > 0), "R1 clav", rx_clav, m_ready > 0);
    chk(rx_data == m_last, "R3 data", rx_data, m_last);
    chk(rx_soc == m_soc, "R3 soc", rx_soc, m_soc);
    chk(in_accept == exp_accept(), "R6 accept", in_accept, exp_accept());
    chk(irq == ((m_ovr && m_oen) || (m_und && m_uen)), "R9 irq", irq,
        (m_ovr && m_oen) || (m_und && m_uen));
    if (rd_now) chk(cpu_rdata == m_rdata, d_tag, cpu_rdata, m_rdata);
    d_wr = 0; d_rd = 0;
  endtask

  task automatic cpu_write(logic a, logic [7:0] v);
    d_addr = a; d_wdata = v; d_wr = 1; tick();
  endtask

  task automatic cpu_read(logic a, string tag);
    d_addr = a; d_rd = 1; d_tag = tag; tick();
  endtask

  task automatic put_cell(logic [15:0] base);
    for (int i = 0; i < NW; i++) begin
      d_valid = 1; d_data = base + 16'(i); tick();
    end
    d_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(rx_clav == 0, "R1 reset clav", rx_clav, 0);
    chk(rx_soc == 0, "R3 reset soc", rx_soc, 0);
    chk(in_accept == 1, "R6 reset accept", in_accept, 1);
    chk(irq == 0, "R9 reset irq", irq, 0);
    cpu_read(1'b1, "R5 status after reset");
    chk(cpu_rdata == 8'h01, "R10 status held", cpu_rdata, 8'h01);

    cpu_write(1'b0, 8'h30);
    cpu_read(1'b0, "R8 enables readback");

    // one cell in, read it out; flag drops after word 0 yet the cell completes
    put_cell(16'h1000);
    d_en_n = 0; tick();
    chk(rx_clav == 0, "R2 clav low mid-cell", rx_clav, 0);
    for (int i = 1; i < NW; i++) tick();
    chk(rx_data == 16'h1000 + 16'(NW - 1), "R2 last word delivered", rx_data, 16'h1000 + NW - 1);

    // underrun at a boundary with nothing ready
    tick();
    d_en_n = 1;
    chk(irq == 1, "R7 underrun raises irq", irq, 1);
    cpu_read(1'b0, "R7 underrun flag");
    cpu_read(1'b0, "R8 flags cleared by read");

    // fill every slot, then offer one more cell
    for (int c = 0; c < NC; c++) put_cell(16'h2000 + 16'(c * 16'h100));
    cpu_read(1'b1, "R5 full status");
    put_cell(16'h7000);
    cpu_read(1'b0, "R6 overrun flag");
    cpu_write(1'b1, 8'hFF);
    cpu_read(1'b1, "R5 status write ignored");

    // drain two cells in order
    d_en_n = 0;
    for (int i = 0; i < 2 * NW; i++) tick();
    d_en_n = 1;

    // flush
    cpu_write(1'b0, 8'h70);
    chk(rx_clav == 0, "R4 clav after flush", rx_clav, 0);
    cpu_read(1'b1, "R4 empty after flush");
    cpu_read(1'b0, "R8 flush bit reads zero");

    // random traffic
    for (int n = 0; n < 6000; n++) begin
      int r;
      d_valid = ($urandom % 10) < 6;
      d_data  = 16'($urandom);
      d_en_n  = ($urandom % 10) < 4;
      r = $urandom % 1000;
      if (r < 10) begin
        d_addr = 1'b1; d_rd = 1; d_tag = "R5 random status";
      end else if (r < 20) begin
        d_addr = 1'b0; d_rd = 1; d_tag = "R8 random flags";
      end else if (r < 22) begin
        d_addr = 1'b0; d_wr = 1; d_wdata = 8'h40 | (8'($urandom) & 8'h30);
      end
      tick();
    end
    d_valid = 0; d_en_n = 1;
    cpu_read(1'b1, "R5 final status");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule